// File: doc/BRIEF.md
# Serial Receiver with Error Flags

This block turns an asynchronous serial input into characters held in a receive buffer. A free-running tick at sixteen times the bit rate paces it; the divider that makes the tick sits outside. A low level on the line that is still low halfway through its bit starts a frame. Each following bit is sampled once, in the middle of its sixteen ticks, and when the last stop bit has been sampled the character moves into the buffer register.

Software-side logic reads `buf_data_o` and pulses `rd_strobe_i` to mark the buffer as consumed. A character that lands while the buffer is still unread replaces the old one and raises the overrun flag instead of the interrupt. Parity and stop-bit checks set their own sticky flags, and a combined error output ORs all three. In a multi-drop setup, the sleep option discards every character whose top data bit is 0, so only address characters wake the node.

Top module: `serial_rx_flags`

## Requirements
- R1: After reset `buf_data_o` is 0, every error flag and `err_sum_o` are 0 and `rx_irq_o` is 0.
- R2: While `rx_en_i` is 0, the line is ignored: no interrupt, and the buffer keeps its value.
- R3: A frame starts on a low line level seen at a tick. It is dropped as noise if the line is high again at the eighth tick after that, which is mid start bit. Every later bit is sampled sixteen ticks after the previous sample.
- R4: `char_len_i` selects the character length: 00 gives 7 bits, 01 gives 8 bits, 10 or 11 give 9 bits. Bits arrive least significant first and are right-aligned in `buf_data_o`, with the unused upper bits 0.
- R5: When a character is written into an empty buffer, `rx_irq_o` is high for exactly one clock cycle.
- R6: If a character completes while the buffer is still unread, the buffer takes the new character, `ovr_err_o` goes to 1 and no interrupt pulse is produced. `rd_strobe_i` marks the buffer as read.
- R7: With `two_stop_i` set, two stop bits are expected, otherwise one. `frm_err_o` goes to 1 if any expected stop bit is sampled low.
- R8: With `par_en_i` set, one parity bit follows the character. `par_err_o` goes to 1 when the number of ones in the character and parity bits, taken at line level, is odd while `par_odd_i` is 0, or even while `par_odd_i` is 1.
- R9: `err_sum_o` is the OR of the overrun, framing and parity flags.
- R10: The error flags stay set until `rx_en_i` is 0, which clears them in the next cycle.
- R11: `rxd_inv_i` inverts the entire input line, idle level included. `data_inv_i` inverts only the character bits before they are buffered, and parity is checked on the bits as received.
- R12: With `sleep_i` set, a character whose top data bit is 0 (after data inversion) is discarded: the buffer, the flags and the interrupt stay untouched. A character with top bit 1 is received normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enable; 0 clears the error flags |
| tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd_i | input | 1 | Serial input pin |
| rxd_inv_i | input | 1 | Invert the whole input line |
| data_inv_i | input | 1 | Invert the received character bits |
| char_len_i | input | 2 | Character length select |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop_i | input | 1 | Expect two stop bits |
| sleep_i | input | 1 | Accept only characters with top bit 1 |
| rd_strobe_i | input | 1 | Buffer has been read |
| buf_data_o | output | 9 | Receive buffer, right-aligned |
| ovr_err_o | output | 1 | Overrun flag |
| frm_err_o | output | 1 | Framing error flag |
| par_err_o | output | 1 | Parity error flag |
| err_sum_o | output | 1 | Any error flag set |
| rx_irq_o | output | 1 | Receive interrupt pulse |

## Verification
The assertions watch, on every cycle, the properties that hold no matter what data arrives: the interrupt is a single-cycle pulse, the interrupt is never raised while reception is disabled or when an overrun is recorded, the buffer changes only when a frame completes, the flags clear once reception is disabled, and a start bit that is high at mid-bit sends the engine back to idle. The values themselves can only be shown by the directed scenarios: the bit order and alignment for each length, which parity sense is flagged, the two inversion options, the sleep filter and the overrun replacement.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int unsigned CHAR_W = 9;
  localparam int unsigned LEN_W  = $clog2(CHAR_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
  } rx_state_e;

  function automatic logic [LEN_W-1:0] char_len_f(input logic [1:0] code);
    case (code)
      2'b00:   return LEN_W'(7);
      2'b01:   return LEN_W'(8);
      default: return LEN_W'(9);
    endcase
  endfunction
endpackage

// File: rtl/rx_line_front.sv
module rx_line_front #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  input  logic inv_i,
  output logic line_o
);
  logic [SYNC_STAGES-1:0] sync_q;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= rxd_i ^ inv_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_i ^ inv_i};
    end
  endgenerate

  assign line_o = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/rx_bit_engine.sv
module rx_bit_engine
  import serial_rx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              par_en_i,
  input  logic              two_stop_i,
  output logic              done_o,
  output logic [CHAR_W-1:0] char_o,
  output logic              par_bit_o,
  output logic              stop_ok_o
);
  localparam int unsigned CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  idx_q;
  logic [CHAR_W-1:0] sh_q;
  logic              par_q, stop_ok_q, done_q;
  logic              bit_end;

  assign bit_end = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; cnt_q <= '0; idx_q <= '0; sh_q <= '0;
      par_q <= 1'b0; stop_ok_q <= 1'b1; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
        unique case (state_q)
          ST_IDLE: begin
            cnt_q <= '0;
            if (!line_i) state_q <= ST_START;
          end
          ST_START: if (cnt_q == HALF) begin
            cnt_q     <= '0;
            idx_q     <= '0;
            sh_q      <= '0;
            stop_ok_q <= 1'b1;
            state_q   <= line_i ? ST_IDLE : ST_DATA;  // noise rejection
          end
          ST_DATA: if (bit_end) begin
            sh_q[idx_q] <= line_i;
            idx_q       <= idx_q + 1'b1;
            if ((idx_q + LEN_W'(1)) == len_i)
              state_q <= par_en_i ? ST_PAR : ST_STOP1;
          end
          ST_PAR: if (bit_end) begin
            par_q   <= line_i;
            state_q <= ST_STOP1;
          end
          ST_STOP1: if (bit_end) begin
            stop_ok_q <= line_i;
            if (two_stop_i) state_q <= ST_STOP2;
            else begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
          ST_STOP2: if (bit_end) begin
            stop_ok_q <= stop_ok_q & line_i;
            done_q    <= 1'b1;
            state_q   <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign done_o    = done_q;
  assign char_o    = sh_q;
  assign par_bit_o = par_q;
  assign stop_ok_o = stop_ok_q;

  p_idle_when_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == ST_IDLE));
  p_start_reject_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && state_q == ST_START && cnt_q == HALF && line_i) |=> (state_q == ST_IDLE));
  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/rx_buffer_ctl.sv
module rx_buffer_ctl
  import serial_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              done_i,
  input  logic [CHAR_W-1:0] char_i,
  input  logic              par_bit_i,
  input  logic              stop_ok_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              data_inv_i,
  input  logic              sleep_i,
  input  logic              rd_i,
  output logic [CHAR_W-1:0] buf_o,
  output logic              ovr_o,
  output logic              frm_o,
  output logic              par_o,
  output logic              irq_o
);
  logic [CHAR_W-1:0] mask, raw, data, buf_q;
  logic msb, par_bad, accept, full_q, full_eff;
  logic ovr_q, frm_q, par_q, irq_q;

  always_comb begin
    mask = '0;
    for (int i = 0; i < CHAR_W; i++) mask[i] = (i < int'(len_i));
  end

  assign raw  = char_i & mask;
  assign data = raw ^ (data_inv_i ? mask : '0);

  always_comb begin
    msb = 1'b0;
    for (int i = 0; i < CHAR_W; i++)
      if (i == int'(len_i) - 1) msb = data[i];
  end

  assign par_bad  = par_en_i & (^raw ^ par_bit_i ^ par_odd_i);
  assign accept   = en_i & done_i & ~(sleep_i & ~msb);
  assign full_eff = full_q & ~rd_i;  // a read in the same cycle counts first

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0; full_q <= 1'b0; irq_q <= 1'b0;
      ovr_q <= 1'b0; frm_q <= 1'b0; par_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (rd_i) full_q <= 1'b0;
      if (accept) begin
        buf_q  <= data;
        full_q <= 1'b1;
        if (full_eff) ovr_q <= 1'b1;
        else          irq_q <= 1'b1;
        if (par_bad)    par_q <= 1'b1;
        if (!stop_ok_i) frm_q <= 1'b1;
      end
      if (!en_i) begin
        ovr_q <= 1'b0; frm_q <= 1'b0; par_q <= 1'b0;
      end
    end
  end

  assign buf_o = buf_q;
  assign ovr_o = ovr_q;
  assign frm_o = frm_q;
  assign par_o = par_q;
  assign irq_o = irq_q;

  p_irq_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  p_ovr_no_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> !irq_o);
  p_no_irq_when_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !irq_o);
  p_flags_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !(ovr_o || frm_o || par_o));
  p_buf_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(buf_o));
endmodule

// File: rtl/serial_rx_flags.sv
module serial_rx_flags
  import serial_rx_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              rxd_inv_i,
  input  logic              data_inv_i,
  input  logic [1:0]        char_len_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  input  logic              sleep_i,
  input  logic              rd_strobe_i,
  output logic [CHAR_W-1:0] buf_data_o,
  output logic              ovr_err_o,
  output logic              frm_err_o,
  output logic              par_err_o,
  output logic              err_sum_o,
  output logic              rx_irq_o
);
  logic              line;
  logic [LEN_W-1:0]  len;
  logic              done, par_bit, stop_ok;
  logic [CHAR_W-1:0] chr;

  assign len = char_len_f(char_len_i);

  rx_line_front #(.SYNC_STAGES(SYNC_STAGES)) i_front (
    .clk_i, .rst_ni, .rxd_i, .inv_i(rxd_inv_i), .line_o(line)
  );

  rx_bit_engine #(.OSR(OSR)) i_engine (
    .clk_i, .rst_ni, .en_i(rx_en_i), .tick_i, .line_i(line), .len_i(len),
    .par_en_i, .two_stop_i, .done_o(done), .char_o(chr),
    .par_bit_o(par_bit), .stop_ok_o(stop_ok)
  );

  rx_buffer_ctl i_buffer (
    .clk_i, .rst_ni, .en_i(rx_en_i), .done_i(done), .char_i(chr),
    .par_bit_i(par_bit), .stop_ok_i(stop_ok), .len_i(len), .par_en_i,
    .par_odd_i, .data_inv_i, .sleep_i, .rd_i(rd_strobe_i), .buf_o(buf_data_o),
    .ovr_o(ovr_err_o), .frm_o(frm_err_o), .par_o(par_err_o), .irq_o(rx_irq_o)
  );

  assign err_sum_o = ovr_err_o | frm_err_o | par_err_o;
endmodule

// File: tb/test_serial_rx_flags.sv
module test_serial_rx_flags;
  localparam int CPT     = 4;
  localparam int BIT_CLK = 16 * CPT;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic rx_en = 0, tick = 0, rxd = 1, rxd_inv = 0, data_inv = 0;
  logic [1:0] char_len = 2'b01;
  logic par_en = 0, par_odd = 0, two_stop = 0, sleep = 0, rd = 0;
  logic [8:0] buf_data;
  logic ovr, frm, perr, esum, irq;

  int checks = 0, fails = 0, irq_cnt = 0, tick_div = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tick_div <= (tick_div == CPT - 1) ? 0 : tick_div + 1;
    tick     <= (tick_div == CPT - 1);
    if (irq) irq_cnt <= irq_cnt + 1;
  end

  serial_rx_flags i_serial_rx_flags (
    .clk_i(clk), .rst_ni, .rx_en_i(rx_en), .tick_i(tick), .rxd_i(rxd),
    .rxd_inv_i(rxd_inv), .data_inv_i(data_inv), .char_len_i(char_len),
    .par_en_i(par_en), .par_odd_i(par_odd), .two_stop_i(two_stop),
    .sleep_i(sleep), .rd_strobe_i(rd), .buf_data_o(buf_data),
    .ovr_err_o(ovr), .frm_err_o(frm), .par_err_o(perr), .err_sum_o(esum),
    .rx_irq_o(irq)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int len_of();
    return (char_len == 2'b00) ? 7 : (char_len == 2'b01) ? 8 : 9;
  endfunction

  task automatic drive_bit(input logic lvl);
    rxd = lvl ^ rxd_inv;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic send_frame(input logic [8:0] val, input logic bad_par, input logic bad_stop);
    int n = len_of();
    logic p = par_odd ^ bad_par;
    @(negedge clk);
    drive_bit(1'b0);
    for (int i = 0; i < n; i++) begin
      drive_bit(val[i]);
      p ^= val[i];
    end
    if (par_en) drive_bit(p);
    if (two_stop) drive_bit(1'b1);
    drive_bit(~bad_stop);
    rxd = ~rxd_inv;
    repeat (8) @(negedge clk);
  endtask

  task automatic read_buf();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    check("R1", "buffer after reset", buf_data, 0);
    check("R1", "flags after reset", {ovr, frm, perr, esum}, 0);
    check("R1", "irq after reset", irq, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    rx_en = 1'b1;
  endtask

  task automatic t_lengths();
    int c = irq_cnt;
    char_len = 2'b01;
    send_frame(9'h0A5, 0, 0);
    check("R4", "8-bit char", buf_data, 'h0A5);
    check("R5", "irq pulse count 8-bit", irq_cnt, c + 1);
    check("R1", "no error flags on clean frame", {ovr, frm, perr}, 0);
    read_buf(); char_len = 2'b00; c = irq_cnt;
    send_frame(9'h1D5, 0, 0);
    check("R4", "7-bit char", buf_data, 'h055);
    check("R5", "irq pulse count 7-bit", irq_cnt, c + 1);
    read_buf(); char_len = 2'b10;
    send_frame(9'h1C3, 0, 0);
    check("R4", "9-bit char", buf_data, 'h1C3);
    read_buf(); char_len = 2'b01;
  endtask

  task automatic t_parity();
    par_en = 1; par_odd = 0;
    send_frame(9'h037, 0, 0);
    check("R8", "even parity good", perr, 0);
    read_buf(); par_odd = 1;
    send_frame(9'h037, 0, 0);
    check("R8", "odd parity good", perr, 0);
    read_buf();
    send_frame(9'h037, 1, 0);
    check("R8", "odd parity bad", perr, 1);
    check("R9", "err sum on parity", esum, 1);
    check("R8", "char kept on parity error", buf_data, 'h037);
    @(negedge clk); rx_en = 0;
    repeat (2) @(negedge clk);
    check("R10", "parity flag cleared by disable", perr, 0);
    check("R9", "err sum cleared", esum, 0);
    rx_en = 1; par_en = 0; par_odd = 0;
    read_buf();
  endtask

  task automatic t_framing();
    two_stop = 1;
    send_frame(9'h05A, 0, 1);
    check("R7", "second stop low", frm, 1);
    check("R9", "err sum on framing", esum, 1);
    @(negedge clk); rx_en = 0;
    repeat (100) @(negedge clk);
    check("R10", "framing flag cleared", frm, 0);
    rx_en = 1;
    read_buf();
    send_frame(9'h066, 0, 0);
    check("R7", "two good stops", frm, 0);
    check("R7", "two-stop char", buf_data, 'h066);
    two_stop = 0;
    read_buf();
  endtask

  task automatic t_overrun();
    int c = irq_cnt;
    send_frame(9'h011, 0, 0);
    send_frame(9'h022, 0, 0);
    check("R6", "overwritten char", buf_data, 'h022);
    check("R6", "overrun flag", ovr, 1);
    check("R6", "single irq over two chars", irq_cnt, c + 1);
    check("R9", "err sum on overrun", esum, 1);
    read_buf();
    @(negedge clk); rx_en = 0;
    @(negedge clk); rx_en = 1;
    c = irq_cnt;
    send_frame(9'h033, 0, 0);
    check("R6", "irq after read", irq_cnt, c + 1);
    check("R6", "no overrun after read", ovr, 0);
    read_buf();
  endtask

  task automatic t_noise();
    int c = irq_cnt;
    logic [8:0] b = buf_data;
    @(negedge clk); rxd = 0;
    repeat (3 * CPT) @(negedge clk);
    rxd = 1;
    repeat (300) @(negedge clk);
    check("R3", "glitch gives no irq", irq_cnt, c);
    check("R3", "glitch leaves buffer", buf_data, b);
    send_frame(9'h044, 0, 0);
    check("R3", "frame after glitch", buf_data, 'h044);
    check("R3", "irq after glitch frame", irq_cnt, c + 1);
    read_buf();
  endtask

  task automatic t_disabled();
    int c = irq_cnt;
    @(negedge clk); rx_en = 0;
    send_frame(9'h07E, 0, 0);
    check("R2", "no irq when disabled", irq_cnt, c);
    check("R2", "buffer held when disabled", buf_data, 'h044);
    rx_en = 1;
  endtask

  task automatic t_polarity();
    @(negedge clk); rx_en = 0; rxd_inv = 1; rxd = 0;
    repeat (10) @(negedge clk);
    rx_en = 1;
    send_frame(9'h03C, 0, 0);
    check("R11", "inverted line", buf_data, 'h03C);
    read_buf();
    data_inv = 1; par_en = 1; par_odd = 0;
    send_frame(9'h00F, 0, 0);
    check("R11", "data inversion", buf_data, 'h0F0);
    check("R11", "parity on received bits", perr, 0);
    read_buf();
    @(negedge clk); rx_en = 0; data_inv = 0; par_en = 0; rxd_inv = 0; rxd = 1;
    repeat (10) @(negedge clk);
    rx_en = 1;
  endtask

  task automatic t_sleep();
    int c = irq_cnt;
    logic [8:0] b = buf_data;
    sleep = 1;
    send_frame(9'h012, 0, 0);
    check("R12", "data char skipped irq", irq_cnt, c);
    check("R12", "data char skipped buffer", buf_data, b);
    par_en = 1;
    send_frame(9'h012, 1, 0);
    check("R12", "skipped char sets no flag", perr, 0);
    par_en = 0;
    send_frame(9'h092, 0, 0);
    check("R12", "address char buffered", buf_data, 'h092);
    check("R12", "address char irq", irq_cnt, c + 1);
    sleep = 0;
    read_buf();
  endtask

  initial begin
    t_reset();
    t_lengths();
    t_parity();
    t_framing();
    t_overrun();
    t_noise();
    t_disabled();
    t_polarity();
    t_sleep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule